// File: doc/BRIEF.md
# Register window overflow detector

This block decides, on a call that needs a fresh register window, whether the callee's frame would land on registers still owned by a live caller frame. The register file is divided into `NUM_WIN` windows of four registers each. A window-start mask marks the windows where a live frame begins, and a window base names the current one. The block walks forward from the window after the base and finds the nearest live window. If that window lies within the requested call size (in units of four registers), an overflow is raised.

When an overflow is raised, the block reports three things. The first is the rotate amount that brings the base onto the conflicting frame. The second is the old base, to be saved into the status register. The third is the PC of the faulting instruction, for the exception PC. It also sets the exception-mode flag. One of three overflow exception codes is chosen by how far the next live frame lies beyond the conflicting one, because that distance is the size of the frame to spill. Spilling the registers is left to the handler the code selects.

All results are registered. The code and the flag pulse for exactly one cycle per overflowing request. The rotate amount, saved base and exception PC hold their values until the next overflow.

Top module: `wovf_detector`

## Requirements
- R1: While reset is held and in the cycle after it, `ovf_code`, `excm`, `rot_amt`, `saved_base` and `exc_pc` are all zero.
- R2: A request with `chk_valid` high overflows exactly when some k in 1..`req_size` has `win_start[(win_base+k) mod NUM_WIN]` set. A request with `req_size` = 0, or with no such live window, gives `ovf_code` = 0.
- R3: On an overflow, `rot_amt` is the smallest such k.
- R4: On an overflow, `saved_base` equals the `win_base` of the request and `excm` is 1.
- R5: On an overflow, `exc_pc` equals the `pc` of the request.
- R6: With n the rotate amount, `ovf_code` is 3'b001 (4-register spill) if window (`win_base`+n+1) mod NUM_WIN is live. It is 3'b010 (8-register spill) if that window is not live but (`win_base`+n+2) mod NUM_WIN is. Otherwise it is 3'b100 (12-register spill).
- R7: Results appear in the cycle after the request's clock edge. `ovf_code` and `excm` are high for that single cycle only. After a non-overflowing request, `rot_amt`, `saved_base` and `exc_pc` keep their previous values.
- R8: While `chk_valid` is low, the inputs have no effect: `ovf_code` and `excm` stay 0 and the held outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | Window check request for this cycle |
| win_base | input | $clog2(NUM_WIN) | Current window base |
| win_start | input | NUM_WIN | Live-frame start mask, bit i for window i |
| pc | input | PC_W | PC of the instruction making the request |
| req_size | input | SZ_W | Requested window size in units of four registers (0..3) |
| ovf_code | output | 3 | One-hot overflow code: 001 spill 4, 010 spill 8, 100 spill 12 |
| rot_amt | output | SZ_W | Forward rotation to the conflicting frame |
| saved_base | output | $clog2(NUM_WIN) | Old window base for the status register |
| excm | output | 1 | Exception-mode flag, set with the code |
| exc_pc | output | PC_W | Exception PC of the faulting instruction |

## Verification
Every result of a request is due one clock edge after the edge that captures it. The bench drives each request on a falling edge and compares the outputs on the next falling edge, just before it drives the following request. This keeps requests back to back, so the one-cycle pulse and the hold of the rotate amount, saved base and PC are checked against the previous request. The small configuration of eight windows is swept over every base, every start mask and every request size, with the expected outcome worked out arithmetically by modular window distances. Idle cycles with overflowing inputs then confirm that nothing moves while no request is present.

// File: rtl/wovf_pkg.sv
// Shared types and constants of the window overflow detector.
// Assumes a one-hot code of three overflow kinds, ordered by spill size.
package wovf_pkg;

    typedef logic [2:0] ovf_code_t;

    localparam ovf_code_t CODE_NONE = 3'b000;
    localparam ovf_code_t CODE_OV4  = 3'b001;
    localparam ovf_code_t CODE_OV8  = 3'b010;
    localparam ovf_code_t CODE_OV12 = 3'b100;

    // Saturated distance from the conflicting frame to the one after it.
    localparam int GAP_W   = 2;
    localparam int GAP_SAT = 2;

endpackage

// File: rtl/wovf_scan.sv
// Rotates the window-start mask so that bit i stands for window base+1+i,
// then finds the nearest live window with a trailing-zero count over the
// whole rotated vector. Flags a hit when that window lies within the request.
// Assumes NUM_WIN is a power of two, so window indices wrap by truncation.
module wovf_scan #(
    parameter int NUM_WIN = 16,
    parameter int WB_W    = $clog2(NUM_WIN),
    parameter int SZ_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WB_W-1:0]    win_base,
    input  logic [NUM_WIN-1:0] win_start,
    input  logic [SZ_W-1:0]    req_size,
    output logic [NUM_WIN-1:0] rot_vec,
    output logic               hit,
    output logic [SZ_W-1:0]    rot_amt
);

    localparam int TZ_W = WB_W + 1;

    logic [TZ_W-1:0] tz;

    // Rotation: one mux per bit, selecting window base+1+i modulo NUM_WIN.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_rot
        logic [WB_W-1:0] src_idx;
        assign src_idx    = win_base + WB_W'(i + 1);
        assign rot_vec[i] = win_start[src_idx];
    end

    // Trailing-zero count of the rotated mask; NUM_WIN when it is empty.
    always_comb begin
        tz = TZ_W'(NUM_WIN);
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (rot_vec[i]) begin
                tz = TZ_W'(i);
            end
        end
    end

    // Hit when the live window sits within the requested size.
    always_comb begin
        hit     = (tz < TZ_W'(req_size));
        rot_amt = SZ_W'(tz + TZ_W'(1));
    end

    // R3: the window reached by the rotation is live.
    p_hit_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> win_start[WB_W'(win_base + WB_W'(rot_amt))]);

    // R3: the rotation is nonzero and never exceeds the request.
    p_rot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rot_amt != '0) && (rot_amt <= req_size));

    // R2: a zero-size request never conflicts.
    p_no_hit_size0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == '0) |-> !hit);

endmodule

// File: rtl/wovf_classify.sv
// Picks the overflow kind from the distance between the conflicting frame
// and the next live frame past it, scanning the rotated mask from the
// rotation point. Assumes NUM_WIN >= 8 so the two bits that decide the kind
// never run past the rotated vector.
module wovf_classify
    import wovf_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int SZ_W    = 2
) (
    input  logic [NUM_WIN-1:0] rot_vec,
    input  logic [SZ_W-1:0]    rot_amt,
    output ovf_code_t          code
);

    logic [GAP_W-1:0] gap;
    logic             seen;

    // Trailing-zero count of the rotated mask shifted down by rot_amt, saturated.
    always_comb begin
        gap  = GAP_W'(GAP_SAT);
        seen = 1'b0;
        for (int j = 0; j < NUM_WIN; j++) begin
            if (!seen && (j >= int'(rot_amt)) && rot_vec[j]) begin
                seen = 1'b1;
                if ((j - int'(rot_amt)) < GAP_SAT) begin
                    gap = GAP_W'(j - int'(rot_amt));
                end
            end
        end
    end

    // Map the distance to a one-hot exception kind.
    always_comb begin
        unique case (gap)
            GAP_W'(0): code = CODE_OV4;
            GAP_W'(1): code = CODE_OV8;
            default:   code = CODE_OV12;
        endcase
    end

endmodule

// File: rtl/wovf_out_reg.sv
// Result registers. The code and exception-mode flag pulse for one cycle per
// overflowing request; the rotation, saved base and exception PC are loaded
// on an overflow and held otherwise. Synchronous active-low reset.
module wovf_out_reg
    import wovf_pkg::*;
#(
    parameter int WB_W = 4,
    parameter int SZ_W = 2,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_valid,
    input  logic            hit,
    input  ovf_code_t       code_in,
    input  logic [SZ_W-1:0] rot_in,
    input  logic [WB_W-1:0] win_base,
    input  logic [PC_W-1:0] pc,
    output ovf_code_t       ovf_code,
    output logic [SZ_W-1:0] rot_amt,
    output logic [WB_W-1:0] saved_base,
    output logic            excm,
    output logic [PC_W-1:0] exc_pc
);

    // Capture the outcome of an overflowing request, drop the pulse otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_code   <= CODE_NONE;
            excm       <= 1'b0;
            rot_amt    <= '0;
            saved_base <= '0;
            exc_pc     <= '0;
        end else if (chk_valid && hit) begin
            ovf_code   <= code_in;
            excm       <= 1'b1;
            rot_amt    <= rot_in;
            saved_base <= win_base;
            exc_pc     <= pc;
        end else begin
            ovf_code   <= CODE_NONE;
            excm       <= 1'b0;
        end
    end

    // R8: a code only follows a cycle that carried a request.
    p_code_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_code != CODE_NONE) |-> $past(chk_valid));

    // R6: at most one exception kind at a time.
    p_code_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovf_code));

    // R4: the flag follows a conflict found by the scan.
    p_excm_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        excm |-> $past(hit) && $past(chk_valid));

    // R4: the saved base is the base of the request.
    p_saved_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        excm |-> (saved_base == $past(win_base)));

    // R5: the exception PC is the PC of the request.
    p_exc_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        excm |-> (exc_pc == $past(pc)));

    // R7: without an overflow the held results do not move.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !excm |-> $stable(exc_pc) && $stable(rot_amt) && $stable(saved_base));

endmodule

// File: rtl/wovf_detector.sv
// Register window overflow detector, top level. On a window check request it
// scans the live-frame mask forward from the current base, decides whether
// the callee's frame would overwrite a live frame, and reports the rotation,
// saved base, exception PC and one-hot overflow kind one cycle later.
// Assumes NUM_WIN is a power of two and at least 8, and req_size <= 3.
module wovf_detector
    import wovf_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int PC_W    = 32,
    parameter int SZ_W    = 2,
    localparam int WB_W   = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_valid,
    input  logic [WB_W-1:0]    win_base,
    input  logic [NUM_WIN-1:0] win_start,
    input  logic [PC_W-1:0]    pc,
    input  logic [SZ_W-1:0]    req_size,
    output logic [2:0]         ovf_code,
    output logic [SZ_W-1:0]    rot_amt,
    output logic [WB_W-1:0]    saved_base,
    output logic               excm,
    output logic [PC_W-1:0]    exc_pc
);

    logic [NUM_WIN-1:0] rot_vec;
    logic               hit;
    logic [SZ_W-1:0]    rot_next;
    ovf_code_t          code_next;

    wovf_scan #(
        .NUM_WIN (NUM_WIN),
        .WB_W    (WB_W),
        .SZ_W    (SZ_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_base  (win_base),
        .win_start (win_start),
        .req_size  (req_size),
        .rot_vec   (rot_vec),
        .hit       (hit),
        .rot_amt   (rot_next)
    );

    wovf_classify #(
        .NUM_WIN (NUM_WIN),
        .SZ_W    (SZ_W)
    ) u_classify (
        .rot_vec (rot_vec),
        .rot_amt (rot_next),
        .code    (code_next)
    );

    wovf_out_reg #(
        .WB_W (WB_W),
        .SZ_W (SZ_W),
        .PC_W (PC_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .hit        (hit),
        .code_in    (code_next),
        .rot_in     (rot_next),
        .win_base   (win_base),
        .pc         (pc),
        .ovf_code   (ovf_code),
        .rot_amt    (rot_amt),
        .saved_base (saved_base),
        .excm       (excm),
        .exc_pc     (exc_pc)
    );

endmodule

// File: tb/wovf_detector_bench.sv
// Exhaustive sweep of an eight-window detector: every base, start mask and
// request size, back to back, with expected results from modular distances.
module wovf_detector_bench;

    localparam int NW   = 8;
    localparam int WBW  = 3;
    localparam int PCW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           chk_valid = 1'b0;
    logic [WBW-1:0] win_base = '0;
    logic [NW-1:0]  win_start = '0;
    logic [PCW-1:0] pc = '0;
    logic [1:0]     req_size = '0;
    logic [2:0]     ovf_code;
    logic [1:0]     rot_amt;
    logic [WBW-1:0] saved_base;
    logic           excm;
    logic [PCW-1:0] exc_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [1:0]     hold_rot = '0;
    logic [WBW-1:0] hold_base = '0;
    logic [PCW-1:0] hold_pc = '0;

    always #10 clk = ~clk;

    wovf_detector #(
        .NUM_WIN (NW),
        .PC_W    (PCW),
        .SZ_W    (2)
    ) u_wovf_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .win_base   (win_base),
        .win_start  (win_start),
        .pc         (pc),
        .req_size   (req_size),
        .ovf_code   (ovf_code),
        .rot_amt    (rot_amt),
        .saved_base (saved_base),
        .excm       (excm),
        .exc_pc     (exc_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit live(input int ws, input int idx);
        return ((ws >> (idx % NW)) & 1) != 0;
    endfunction

    // Expected outcome from window distances.
    task automatic model(input int wb, input int ws, input int sz,
                         output bit hit, output int n, output logic [2:0] code);
        hit  = 1'b0;
        n    = 0;
        code = 3'b000;
        for (int k = 1; k <= sz; k++) begin
            if (!hit && live(ws, wb + k)) begin
                hit = 1'b1;
                n   = k;
            end
        end
        if (hit) begin
            if (live(ws, wb + n + 1))      code = 3'b001;
            else if (live(ws, wb + n + 2)) code = 3'b010;
            else                           code = 3'b100;
        end
    endtask

    task automatic expect_idle(input string req);
        check(req, "ovf_code", 64'(ovf_code), 64'(0));
        check(req, "excm", 64'(excm), 64'(0));
        check(req, "rot_amt held", 64'(rot_amt), 64'(hold_rot));
        check(req, "saved_base held", 64'(saved_base), 64'(hold_base));
        check(req, "exc_pc held", 64'(exc_pc), 64'(hold_pc));
    endtask

    // Drive one request at a falling edge, check at the next falling edge.
    task automatic run_one(input int wb, input int ws, input int sz, input logic [PCW-1:0] p);
        bit          hit;
        int          n;
        logic [2:0]  code;
        chk_valid = 1'b1;
        win_base  = WBW'(wb);
        win_start = NW'(ws);
        req_size  = 2'(sz);
        pc        = p;
        model(wb, ws, sz, hit, n, code);
        @(negedge clk);
        if (hit) begin
            check("R2/R6", "ovf_code", 64'(ovf_code), 64'(code));
            check("R3", "rot_amt", 64'(rot_amt), 64'(n));
            check("R4", "saved_base", 64'(saved_base), 64'(wb));
            check("R4", "excm", 64'(excm), 64'(1));
            check("R5", "exc_pc", 64'(exc_pc), 64'(p));
            hold_rot  = 2'(n);
            hold_base = WBW'(wb);
            hold_pc   = p;
        end else begin
            expect_idle((sz == 0) ? "R2 size0/R7" : "R2 none/R7");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        check("R1", "ovf_code", 64'(ovf_code), 64'(0));
        check("R1", "excm", 64'(excm), 64'(0));
        check("R1", "rot_amt", 64'(rot_amt), 64'(0));
        check("R1", "saved_base", 64'(saved_base), 64'(0));
        check("R1", "exc_pc", 64'(exc_pc), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "exc_pc after release", 64'(exc_pc), 64'(0));
        check("R1", "ovf_code after release", 64'(ovf_code), 64'(0));

        // R2 R3 R4 R5 R6 R7: full sweep, back to back
        for (int wb = 0; wb < NW; wb++) begin
            for (int ws = 0; ws < (1 << NW); ws++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    cnt++;
                    run_one(wb, ws, sz, 32'h4000_0000 + PCW'(cnt * 4));
                end
            end
        end

        // R7: overflow then a non-overflowing request keeps results
        run_one(2, 8'b0000_1000, 3, 32'h0000_1230);
        run_one(2, 8'b0000_0000, 3, 32'h0000_5670);
        check("R7", "exc_pc kept", 64'(exc_pc), 64'h1230);

        // R8: overflowing inputs with no request change nothing
        run_one(5, 8'b1000_0000, 2, 32'hABCD_0000);
        chk_valid = 1'b0;
        win_base  = 3'd1;
        win_start = 8'hFF;
        req_size  = 2'd3;
        pc        = 32'h0BAD_0000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_idle("R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule